// File: doc/BRIEF.md
# Event-Triggered DMA Channel Controller With Linking

This controller sits between a set of per-channel synchronisation events and an address-generation engine. Each incoming event pulse is latched as a pending request for its channel. When idle, the controller picks the lowest-numbered pending channel. It reads that channel's six-word parameter set from an internal table, one word per cycle, and presents the set as a transfer descriptor with a valid/ready handshake. It then waits for the engine to report that the transfer has finished.

The table holds one parameter set per channel, followed by a pool of sets that are used only as link targets. A set whose options word has its link bit raised names another table entry through a byte offset. When the current transfer finishes, the controller copies the named entry into the channel's own slot and presents it at once as the next descriptor. The walk continues until it reaches a set whose link bit is clear. An offset that does not land on an entry boundary inside the table raises a one-cycle error pulse and ends the walk. Software fills the table through a simple word-write port.

Top module: `dmac_link_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `desc_valid` and `link_err` are low.
- R2: A one-cycle high on `evt_i[c]` produces exactly one descriptor with `desc_ch = c`, carrying the words of entry c. Entry e occupies word addresses e*6+k. Word k=0 is options, 1 is source, 2 is destination, 3 is count, 4 is index, and 5 is link (bits 15:0 hold the link byte offset, bits 31:16 the count reload).
- R3: When several channels are pending, descriptors are issued in ascending channel order.
- R4: From idle, `desc_valid` first reads high after the eighth rising edge that follows raising `evt_i` (one capture edge, one grant edge and six word reads).
- R5: While `desc_valid` is high and `desc_ready` is low, `desc_valid` stays high and all descriptor fields hold their values.
- R6: After a descriptor is accepted, no descriptor is presented until `xfer_done` has been seen high.
- R7: If options bit 0 (link) is 1 and the offset is valid, then after `xfer_done` the entry at offset/24 is presented next on the same channel, with no new event.
- R8: The walk ends after a descriptor whose options bit 0 is 0, and no further descriptor appears.
- R9: Following a link copies the target's six words into the channel's slot, so a later event on that channel presents the linked parameters.
- R10: An offset that is not a multiple of 24, or whose offset/24 is not below the entry count (85), raises `link_err` for exactly one cycle and presents nothing further.
- R11: An event that arrives on the channel being granted, in the same cycle as the grant, is kept pending and is serviced again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_CH | Per-channel event pulses |
| cfg_we | input | 1 | Table word write strobe |
| cfg_addr | input | AW (9) | Table word address (entry*6 + word) |
| cfg_wdata | input | 32 | Table write data |
| desc_valid | output | 1 | Descriptor valid |
| desc_ready | input | 1 | Address generator accepts descriptor |
| desc_ch | output | CH_W (6) | Channel of the descriptor |
| desc_opt | output | 32 | Options word |
| desc_src | output | 32 | Source address |
| desc_dst | output | 32 | Destination address |
| desc_cnt | output | 32 | Transfer count |
| desc_idx | output | 32 | Index word |
| desc_rld | output | 16 | Count reload value |
| xfer_done | input | 1 | Current transfer finished |
| link_err | output | 1 | One-cycle pulse on an invalid link offset |

## Verification
The grant that clears a channel's pending bit can fall in the same cycle as a fresh event on that channel, and the two must not cancel. The bench holds the event line high across both the capture edge and the following grant edge. It then expects two full descriptors for that channel in its scoreboard. A lost second event shows up as a scoreboard entry that is never matched. Ready is also throttled pseudo-randomly throughout, so a stall can coincide with a just-finished link copy. The bench checks that the held descriptor stays stable.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int WORD_W   = 32;
    localparam int SET_WORDS = 6;
    localparam int SET_BYTES = 24;
    localparam int LINK_BIT = 0;

    // word positions inside one parameter set
    localparam int W_OPT = 0;
    localparam int W_SRC = 1;
    localparam int W_DST = 2;
    localparam int W_CNT = 3;
    localparam int W_IDX = 4;
    localparam int W_LNK = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_SHOW,
        S_WAIT,
        S_COPY
    } seq_st_e;

    // a link offset is usable when it lands on an entry boundary inside the table
    function automatic logic link_ok(input logic [15:0] off, input int n_ent);
        return ((off % 16'd24) == 16'd0) && ((int'(off) / SET_BYTES) < n_ent);
    endfunction

endpackage

// File: rtl/dmac_evt_pend.sv
module dmac_evt_pend #(
    parameter int N_CH = 64,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] evt_i,
    input  logic            clr_en,
    input  logic [CH_W-1:0] clr_idx,
    output logic            any_o,
    output logic [CH_W-1:0] low_idx_o
);

    logic [N_CH-1:0] pend;
    logic [N_CH-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_en) clr_mask[clr_idx] = 1'b1;
    end

    // a new event wins over the clear of the same bit
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_mask) | evt_i;
    end

    // lowest index wins
    always_comb begin
        low_idx_o = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (pend[i]) low_idx_o = CH_W'(i);
        end
    end

    assign any_o = |pend;

    a_r2_clear_on_grant: assert property (@(posedge clk) disable iff (rst)
        clr_en && !evt_i[clr_idx] |=> !pend[$past(clr_idx)]);

    a_r11_event_kept: assert property (@(posedge clk) disable iff (rst)
        clr_en && evt_i[clr_idx] |=> pend[$past(clr_idx)]);

    a_r3_grant_pending: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> $onehot0(pend & clr_mask) && (pend[clr_idx]));

endmodule

// File: rtl/dmac_param_ram.sv
module dmac_param_ram #(
    parameter int N_ENT = 85,
    localparam int N_W = N_ENT * dmac_pkg::SET_WORDS,
    localparam int AW = $clog2(N_W)
) (
    input  logic          clk,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          int_we,
    input  logic [AW-1:0] int_addr,
    input  logic [31:0]   int_wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data
);

    logic [31:0] mem [N_W];

    // link copy takes the single write port over software writes
    always_ff @(posedge clk) begin
        if (int_we)
            mem[int_addr] <= int_wdata;
        else if (cfg_we && (int'(cfg_addr) < N_W))
            mem[cfg_addr] <= cfg_wdata;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int N_CH = 64,
    parameter int N_ENT = 85,
    localparam int CH_W = $clog2(N_CH),
    localparam int EW = $clog2(N_ENT),
    localparam int AW = $clog2(N_ENT * SET_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            any_pend,
    input  logic [CH_W-1:0] low_idx,
    output logic            clr_en,
    output logic [CH_W-1:0] clr_idx,
    output logic [AW-1:0]   rd_addr,
    input  logic [31:0]     rd_data,
    output logic            int_we,
    output logic [AW-1:0]   int_addr,
    output logic [31:0]     int_wdata,
    output logic            desc_valid,
    input  logic            desc_ready,
    output logic [CH_W-1:0] desc_ch,
    output logic [31:0]     desc_opt,
    output logic [31:0]     desc_src,
    output logic [31:0]     desc_dst,
    output logic [31:0]     desc_cnt,
    output logic [31:0]     desc_idx,
    output logic [15:0]     desc_rld,
    input  logic            xfer_done,
    output logic            link_err
);

    seq_st_e         st;
    logic [CH_W-1:0] ch_q;
    logic [2:0]      wd;
    logic [EW-1:0]   tgt;
    logic [31:0]     wbuf [SET_WORDS];

    logic [15:0]     lnk_off;
    logic            lnk_good;
    logic [EW-1:0]   lnk_ent;
    logic [AW-1:0]   own_addr;
    logic [AW-1:0]   tgt_addr;
    logic            last_wd;

    assign lnk_off  = wbuf[W_LNK][15:0];
    assign lnk_good = link_ok(lnk_off, N_ENT);
    assign lnk_ent  = EW'(lnk_off / 16'd24);
    assign own_addr = AW'(int'(ch_q) * SET_WORDS + int'(wd));
    assign tgt_addr = AW'(int'(tgt) * SET_WORDS + int'(wd));
    assign last_wd  = (wd == 3'(SET_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            ch_q     <= '0;
            wd       <= '0;
            tgt      <= '0;
            link_err <= 1'b0;
        end else begin
            link_err <= 1'b0;
            case (st)
                S_IDLE: if (any_pend) begin
                    ch_q <= low_idx;
                    wd   <= '0;
                    st   <= S_FETCH;
                end
                S_FETCH, S_COPY: begin
                    if (last_wd) begin
                        wd <= '0;
                        st <= S_SHOW;
                    end else begin
                        wd <= wd + 3'd1;
                    end
                end
                S_SHOW: if (desc_ready) st <= S_WAIT;
                S_WAIT: if (xfer_done) begin
                    if (!wbuf[W_OPT][LINK_BIT]) begin
                        st <= S_IDLE;
                    end else if (lnk_good) begin
                        tgt <= lnk_ent;
                        wd  <= '0;
                        st  <= S_COPY;
                    end else begin
                        link_err <= 1'b1;
                        st       <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // the staging buffer fills during a fetch and during a link copy alike
    always_ff @(posedge clk) begin
        if (st == S_FETCH || st == S_COPY) wbuf[wd] <= rd_data;
    end

    assign clr_en    = (st == S_IDLE) && any_pend;
    assign clr_idx   = low_idx;
    assign rd_addr   = (st == S_COPY) ? tgt_addr : own_addr;
    assign int_we    = (st == S_COPY);
    assign int_addr  = own_addr;
    assign int_wdata = rd_data;

    assign desc_valid = (st == S_SHOW);
    assign desc_ch    = ch_q;
    assign desc_opt   = wbuf[W_OPT];
    assign desc_src   = wbuf[W_SRC];
    assign desc_dst   = wbuf[W_DST];
    assign desc_cnt   = wbuf[W_CNT];
    assign desc_idx   = wbuf[W_IDX];
    assign desc_rld   = wbuf[W_LNK][31:16];

    a_r4_fetch_then_show: assert property (@(posedge clk) disable iff (rst)
        st == S_FETCH && last_wd |=> desc_valid);

    a_r5_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_ch)
            && $stable(desc_src) && $stable(desc_dst) && $stable(desc_cnt)
            && $stable(desc_opt) && $stable(desc_idx));

    a_r6_quiet_until_done: assert property (@(posedge clk) disable iff (rst)
        st == S_WAIT && !xfer_done |=> !desc_valid);

    a_r7_copy_then_show: assert property (@(posedge clk) disable iff (rst)
        st == S_COPY && last_wd |=> desc_valid && $stable(desc_ch));

    a_r10_err_after_done: assert property (@(posedge clk) disable iff (rst)
        link_err |-> $past(xfer_done) && !desc_valid);

endmodule

// File: rtl/dmac_link_ctrl.sv
module dmac_link_ctrl #(
    parameter int N_CH = 64,
    parameter int N_LINK = 21,
    localparam int N_ENT = N_CH + N_LINK,
    localparam int CH_W = $clog2(N_CH),
    localparam int AW = $clog2(N_ENT * dmac_pkg::SET_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] evt_i,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic            desc_valid,
    input  logic            desc_ready,
    output logic [CH_W-1:0] desc_ch,
    output logic [31:0]     desc_opt,
    output logic [31:0]     desc_src,
    output logic [31:0]     desc_dst,
    output logic [31:0]     desc_cnt,
    output logic [31:0]     desc_idx,
    output logic [15:0]     desc_rld,
    input  logic            xfer_done,
    output logic            link_err
);

    logic            any_pend;
    logic [CH_W-1:0] low_idx;
    logic            clr_en;
    logic [CH_W-1:0] clr_idx;
    logic [AW-1:0]   rd_addr;
    logic [31:0]     rd_data;
    logic            int_we;
    logic [AW-1:0]   int_addr;
    logic [31:0]     int_wdata;

    dmac_evt_pend #(.N_CH(N_CH)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .any_o     (any_pend),
        .low_idx_o (low_idx)
    );

    dmac_param_ram #(.N_ENT(N_ENT)) u_ram (
        .clk       (clk),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .int_we    (int_we),
        .int_addr  (int_addr),
        .int_wdata (int_wdata),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    dmac_seq #(.N_CH(N_CH), .N_ENT(N_ENT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .any_pend   (any_pend),
        .low_idx    (low_idx),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .int_we     (int_we),
        .int_addr   (int_addr),
        .int_wdata  (int_wdata),
        .desc_valid (desc_valid),
        .desc_ready (desc_ready),
        .desc_ch    (desc_ch),
        .desc_opt   (desc_opt),
        .desc_src   (desc_src),
        .desc_dst   (desc_dst),
        .desc_cnt   (desc_cnt),
        .desc_idx   (desc_idx),
        .desc_rld   (desc_rld),
        .xfer_done  (xfer_done),
        .link_err   (link_err)
    );

endmodule

// File: tb/dmac_link_ctrl_tb.sv
`timescale 1ns/1ps
module dmac_link_ctrl_tb;

    localparam int N_CH = 64;
    localparam int N_ENT = 85;
    localparam int AW = 9;

    typedef struct packed {
        logic [5:0]  ch;
        logic [31:0] opt;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] cnt;
        logic [31:0] idx;
        logic [15:0] rld;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N_CH-1:0] evt_i = '0;
    logic            cfg_we = 1'b0;
    logic [AW-1:0]   cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic            desc_valid;
    logic            desc_ready = 1'b0;
    logic [5:0]      desc_ch;
    logic [31:0]     desc_opt, desc_src, desc_dst, desc_cnt, desc_idx;
    logic [15:0]     desc_rld;
    logic            xfer_done = 1'b0;
    logic            link_err;

    int tests = 0;
    int fails = 0;
    int exp_err = 0;
    int err_seen = 0;
    logic [31:0] mdl [N_ENT*6];
    exp_t exp_q [$];
    logic busy_b = 1'b0;
    logic mon_on = 1'b0;

    always #2.5 clk = ~clk;

    dmac_link_ctrl u_dut (
        .clk(clk), .rst(rst), .evt_i(evt_i),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_ch(desc_ch),
        .desc_opt(desc_opt), .desc_src(desc_src), .desc_dst(desc_dst),
        .desc_cnt(desc_cnt), .desc_idx(desc_idx), .desc_rld(desc_rld),
        .xfer_done(xfer_done), .link_err(link_err)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        mdl[a] = v;
    endtask

    task automatic set_entry(input int e, input logic [31:0] opt, input logic [31:0] lnk);
        wr(e*6+0, opt);
        wr(e*6+1, 32'h1000_0000 + 32'(e));
        wr(e*6+2, 32'h2000_0000 + 32'(e));
        wr(e*6+3, 32'h0000_0100 + 32'(e));
        wr(e*6+4, 32'h0004_0000 + 32'(e));
        wr(e*6+5, lnk);
    endtask

    // expected descriptors for one event on channel ch, walking links
    task automatic push_chain(input int ch);
        exp_t it;
        logic [15:0] off;
        for (int n = 0; n < 32; n++) begin
            it.ch  = 6'(ch);
            it.opt = mdl[ch*6+0]; it.src = mdl[ch*6+1]; it.dst = mdl[ch*6+2];
            it.cnt = mdl[ch*6+3]; it.idx = mdl[ch*6+4]; it.rld = mdl[ch*6+5][31:16];
            exp_q.push_back(it);
            if (!it.opt[0]) break;
            off = mdl[ch*6+5][15:0];
            if ((off % 16'd24) != 0 || (int'(off) / 24) >= N_ENT) begin
                exp_err++;
                break;
            end
            for (int k = 0; k < 6; k++) mdl[ch*6+k] = mdl[(int'(off)/24)*6+k];
        end
    endtask

    task automatic pulse(input logic [N_CH-1:0] m);
        @(negedge clk);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !busy_b && !desc_valid) break;
        end
        repeat (20) @(negedge clk);
    endtask

    // monitor: drives ready and done, pops the scoreboard on handshakes
    initial begin
        logic [15:0] lfsr = 16'hACE1;
        logic prev_stall = 1'b0;
        logic [31:0] ps = '0;
        logic [5:0] pc = '0;
        int dly = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                xfer_done = 1'b0;
                if (link_err) err_seen++;
                if (busy_b) begin
                    chk(!desc_valid, "R6 no descriptor before done", 64'(desc_valid), 64'd0);
                    if (dly == 0) begin xfer_done = 1'b1; busy_b = 1'b0; end
                    else dly--;
                end
                if (prev_stall) begin
                    chk(desc_valid && desc_src == ps && desc_ch == pc, "R5 held while stalled",
                        {desc_ch, desc_src}, {pc, ps});
                end
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                desc_ready = lfsr[0] | lfsr[1];
                prev_stall = desc_valid && !desc_ready;
                ps = desc_src; pc = desc_ch;
                if (desc_valid && desc_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected descriptor", 64'(desc_ch), 64'hFFFF);
                    end else begin
                        e = exp_q.pop_front();
                        chk(desc_ch == e.ch && desc_opt == e.opt && desc_src == e.src
                            && desc_dst == e.dst && desc_cnt == e.cnt && desc_idx == e.idx
                            && desc_rld == e.rld,
                            "R2/R3/R7/R9 descriptor contents", {desc_ch, desc_src}, {e.ch, e.src});
                    end
                    busy_b = 1'b1;
                    dly = 2;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        chk(!desc_valid && !link_err, "R1 reset outputs", {desc_valid, link_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!desc_valid && !link_err, "R1 after reset", {desc_valid, link_err}, 0);

        // table contents; link offsets: entry 64 = 1536, entry 70 = 1680
        set_entry(2,  32'h0000_0010, 32'h0011_0000);
        set_entry(3,  32'h0000_0020, 32'h0022_0000);
        set_entry(5,  32'h0000_0030, 32'h0033_0000);
        set_entry(9,  32'h0000_0040, 32'h0044_0000);
        set_entry(7,  32'h0000_0051, 32'h0055_0000 | 32'd1536);
        set_entry(64, 32'h0000_0061, 32'h0066_0000 | 32'd1680);
        set_entry(70, 32'h0000_0070, 32'h0077_0000);
        set_entry(10, 32'h0000_0081, 32'h0088_0000 | 32'd25);
        set_entry(11, 32'h0000_0091, 32'h0099_0000 | 32'd2040);
        set_entry(20, 32'h0000_00A0, 32'h00AA_0000);
        mon_on = 1'b1;

        // R2 and R4: single event, count edges to valid
        push_chain(3);
        @(negedge clk);
        evt_i[3] = 1'b1;
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            evt_i = '0;
            cnt++;
            if (desc_valid) break;
        end
        chk(cnt == 8, "R4 fetch latency", 64'(cnt), 64'd8);
        wait_idle();
        chk(exp_q.size() == 0, "R2 single descriptor served", 64'(exp_q.size()), 0);

        // R3: simultaneous events 9, 5, 2
        push_chain(2); push_chain(5); push_chain(9);
        pulse(64'h0000_0000_0000_0224);
        wait_idle();
        chk(exp_q.size() == 0, "R3 ordered service", 64'(exp_q.size()), 0);

        // R7, R8: chain 7 -> 64 -> 70 -> end
        push_chain(7);
        pulse(64'h80);
        wait_idle();
        chk(exp_q.size() == 0, "R7/R8 chain walked and ended", 64'(exp_q.size()), 0);

        // R9: slot 7 now holds entry 70
        push_chain(7);
        chk(mdl[7*6+1] == 32'h1000_0046, "R9 model slot after link", 64'(mdl[7*6+1]), 64'h1000_0046);
        pulse(64'h80);
        wait_idle();
        chk(exp_q.size() == 0, "R9 linked parameters reused", 64'(exp_q.size()), 0);

        // R10: misaligned and out-of-table offsets
        push_chain(10);
        pulse(64'h400);
        wait_idle();
        push_chain(11);
        pulse(64'h800);
        wait_idle();
        chk(err_seen == exp_err && exp_err == 2, "R10 link error pulses", 64'(err_seen), 64'd2);
        chk(exp_q.size() == 0, "R10 no descriptor after error", 64'(exp_q.size()), 0);

        // R11: event held across capture and grant edges
        push_chain(20); push_chain(20);
        @(negedge clk);
        evt_i[20] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        evt_i = '0;
        wait_idle();
        chk(exp_q.size() == 0, "R11 re-arrival serviced twice", 64'(exp_q.size()), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule